// File: doc/BRIEF.md
# Guarded security-store access controller

This block sits between a host and a one-time-programmable word array that holds a device's security fields: two 128-bit bitstream keys, four 64-bit re-keying master keys, a 32-bit masking seed, a 160-bit lifecycle counter, a feature word, a test-disable word, a 128-bit rollback counter, a chip identifier and a scan-port identifier. The array is 32-bit words wide, so a field wider than 32 bits occupies consecutive word addresses. The host sends one request at a time: an operation, an address and data. It then waits for a one-cycle acknowledge that carries a status code and, for reads, the word.

The controller refuses all work until a self-test has scanned the array and found it consistent. Reads are then allowed. Programming needs a two-step unlock on a separate supplementary address space. Every mapped word may be programmed only once: a word that carries an error-correcting signature would be corrupted by a second write, and the identifier words lock once written. The lifecycle words cannot be written until both identifier words exist. The feature and test-disable words are format-checked, and their live fields are decoded onto dedicated outputs.

Word map (word addresses): 0-3 authentication key, 4-7 decryption key, 8-15 the four re-keying keys (two words each), 16 seed, 17-21 lifecycle, 22 feature, 23 test-disable, 24-27 rollback counter, 28 chip ID, 29 scan-port ID. Addresses 30 and up are unmapped.

Top module: `otp_guard`

## Requirements
- R1: After reset, ack, wr_open, test_ok and unlock_err are all 0.
- R2: Until a self-test has passed, every read, program or unlock request is acknowledged with status 1 (not tested), the array is unchanged, and the unlock state does not move.
- R3: Operation code 2 starts a self-test. It scans every word of the array and then acknowledges with status 0, and test_ok goes to 1.
- R4: Writes open (wr_open=1) only after an unlock request (operation code 3) with supplementary address 3 and data 0x5555, followed directly by one with address 4 and data 0xAAAA. A program request (operation code 1) while locked gets status 2 and writes nothing.
- R5: An unlock request that does not fit the expected step returns status 7, puts the sequence back at its first step, keeps writes locked and sets unlock_err. A later complete sequence clears unlock_err.
- R6: A read (operation code 0) of a mapped address returns status 0 with the stored word, which is 0 when the word has never been programmed. Any read or program at address 30 or above returns status 5.
- R7: A second program request to an already programmed word returns status 3, and the word keeps its first value.
- R8: A program request to a lifecycle word (17 to 21) returns status 4 and writes nothing unless words 28 and 29 have both been programmed.
- R9: A program request to word 22 with any of bits 31:16 set, or to word 23 with any of bits 31:3 set, returns status 6 and writes nothing.
- R10: cfg_max_err shows bits 7:0 of word 22, cfg_rekey_en shows bits 15:8 of word 22, and cfg_test_off shows bits 2:0 of word 23.
- R11: Every request other than self-test is acknowledged in the cycle after it is accepted. The acknowledge is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 2 | 0 read, 1 program, 2 self-test, 3 unlock write |
| req_addr | input | AW | Word address (supplementary address for unlock) |
| req_wdata | input | 32 | Program or unlock data |
| ack | output | 1 | Request completed |
| ack_status | output | 3 | 0 ok, 1 not tested, 2 locked, 3 already programmed, 4 order, 5 range, 6 format, 7 bad unlock |
| rd_data | output | 32 | Read word, valid with ack |
| test_ok | output | 1 | Self-test has passed |
| wr_open | output | 1 | Write unlock complete |
| unlock_err | output | 1 | Last unlock attempt was out of sequence |
| cfg_max_err | output | 8 | Decoded maximum run-error count |
| cfg_rekey_en | output | 8 | Decoded re-keying enable |
| cfg_test_off | output | 3 | Decoded test-disable bits |

## Verification
The assertions check four rules on every cycle. The array is never written before the self-test passes or while writes are locked. No write lands on a programmed word. No lifecycle word is written before both identifiers exist. Each non-self-test request is acknowledged in the next cycle. Checks that need history come from the bench's scenarios: the write-once data keeping its first value, the exact status code for each refusal, the unlock error clearing on a good sequence, the field decode, and read-back after programming.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_TEST = 2'd2, OP_UNLK = 2'd3} op_e;
  typedef enum logic [2:0] {
    ST_OK = 3'd0, ST_NOTEST = 3'd1, ST_LOCKED = 3'd2, ST_ONCE = 3'd3,
    ST_ORDER = 3'd4, ST_RANGE = 3'd5, ST_FORMAT = 3'd6, ST_BADKEY = 3'd7
  } stat_e;

  localparam int unsigned MAP_WORDS = 30;
  localparam int unsigned LIFE_LO   = 17;
  localparam int unsigned LIFE_HI   = 21;
  localparam int unsigned FEAT_W    = 22;
  localparam int unsigned TDIS_W    = 23;
  localparam int unsigned CHIP_W    = 28;
  localparam int unsigned JTAG_W    = 29;
  localparam int unsigned UNLK_A1   = 3;
  localparam int unsigned UNLK_A2   = 4;
  localparam logic [31:0] UNLK_D1   = 32'h0000_5555;
  localparam logic [31:0] UNLK_D2   = 32'h0000_AAAA;

  function automatic logic is_life(input logic [31:0] a);
    return (a >= LIFE_LO) && (a <= LIFE_HI);
  endfunction

  function automatic logic in_map(input logic [31:0] a);
    return a < MAP_WORDS;
  endfunction

  // reserved bits of the two packed configuration words must stay clear
  function automatic logic fmt_ok(input logic [31:0] a, input logic [31:0] d);
    if (a == FEAT_W) return d[31:16] == 16'h0;
    if (a == TDIS_W) return d[31:3] == 29'h0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_guard_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata,
  output logic          rprog,
  input  logic [AW-1:0] scan_addr,
  output logic [31:0]   scan_data,
  output logic          scan_prog,
  output logic          ids_done,
  output logic [31:0]   feat_word,
  output logic [31:0]   tdis_word
);
  logic [31:0]      mem [DEPTH];
  logic [DEPTH-1:0] prog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      prog <= '0;
    end else if (we) begin
      mem[waddr]  <= wdata;
      prog[waddr] <= 1'b1;
    end
  end

  assign rdata     = mem[raddr];
  assign rprog     = prog[raddr];
  assign scan_data = mem[scan_addr];
  assign scan_prog = prog[scan_addr];
  assign ids_done  = prog[CHIP_W] && prog[JTAG_W];
  assign feat_word = mem[FEAT_W];
  assign tdis_word = mem[TDIS_W];

  // R7: a write never lands on a word already programmed
  p_no_rewrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !prog[waddr]);
  // R8: lifecycle words only after both identifier words
  p_life_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && is_life(32'(waddr))) |-> (prog[CHIP_W] && prog[JTAG_W]));
endmodule

// File: rtl/otp_unlock_seq.sv
module otp_unlock_seq
  import otp_guard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   data,
  output logic          open_o,
  output logic          err_o,
  output logic          bad_o
);
  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} ul_e;
  ul_e state;

  logic step1, step2;
  assign step1  = (state == UL_IDLE) && (32'(addr) == UNLK_A1) && (data == UNLK_D1);
  assign step2  = (state == UL_HALF) && (32'(addr) == UNLK_A2) && (data == UNLK_D2);
  assign bad_o  = strobe && (state != UL_OPEN) && !step1 && !step2;
  assign open_o = (state == UL_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= UL_IDLE;
      err_o <= 1'b0;
    end else if (strobe && state != UL_OPEN) begin
      if (step1) state <= UL_HALF;
      else if (step2) begin
        state <= UL_OPEN;
        err_o <= 1'b0;
      end else begin
        state <= UL_IDLE;
        err_o <= 1'b1;
      end
    end
  end

  // R5: a bad step leaves writes locked and raises the error flag
  p_bad_relocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_o |=> (!open_o && err_o));
  // R4: opening only happens on a strobe
  p_open_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_o && !strobe) |=> !open_o);
endmodule

// File: rtl/otp_selftest.sv
module otp_selftest #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   scan_data,
  input  logic          scan_prog,
  output logic [AW-1:0] scan_addr,
  output logic          busy,
  output logic          done,
  output logic          pass
);
  logic clean, clean_nx;
  // a word never programmed must read blank
  assign clean_nx = clean && (scan_prog || scan_data == 32'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      clean     <= 1'b1;
      scan_addr <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy      <= 1'b1;
        pass      <= 1'b0;
        clean     <= 1'b1;
        scan_addr <= '0;
      end else if (busy) begin
        clean <= clean_nx;
        if (32'(scan_addr) == DEPTH - 1) begin
          busy <= 1'b0;
          done <= 1'b1;
          pass <= clean_nx;
        end else begin
          scan_addr <= scan_addr + 1'b1;
        end
      end
    end
  end

  // R3: the pass flag only rises at the end of a scan
  p_pass_after_scan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> (done && $past(busy)));
endmodule

// File: rtl/otp_guard.sv
module otp_guard
  import otp_guard_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          ack,
  output logic [2:0]    ack_status,
  output logic [31:0]   rd_data,
  output logic          test_ok,
  output logic          wr_open,
  output logic          unlock_err,
  output logic [7:0]    cfg_max_err,
  output logic [7:0]    cfg_rekey_en,
  output logic [2:0]    cfg_test_off
);
  op_e         op;
  logic [31:0] addr32;
  logic [31:0] arr_rdata, scan_data, feat_word, tdis_word;
  logic        arr_rprog, scan_prog, ids_done;
  logic [AW-1:0] scan_addr;
  logic        st_busy, st_done, st_pass;
  logic        ul_strobe, ul_bad;
  logic        arr_we;
  stat_e       req_stat;
  logic        ack_q;
  stat_e       stat_q;

  assign op     = op_e'(req_op);
  assign addr32 = 32'(req_addr);

  otp_cell_array #(.DEPTH(DEPTH)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(req_addr), .wdata(req_wdata),
    .raddr(req_addr), .rdata(arr_rdata), .rprog(arr_rprog),
    .scan_addr(scan_addr), .scan_data(scan_data), .scan_prog(scan_prog),
    .ids_done(ids_done), .feat_word(feat_word), .tdis_word(tdis_word)
  );

  otp_selftest #(.DEPTH(DEPTH)) u_test (
    .clk(clk), .rst_n(rst_n), .start(req_valid && op == OP_TEST),
    .scan_data(scan_data), .scan_prog(scan_prog), .scan_addr(scan_addr),
    .busy(st_busy), .done(st_done), .pass(st_pass)
  );

  assign ul_strobe = req_valid && op == OP_UNLK && st_pass;

  otp_unlock_seq #(.AW(AW)) u_unlock (
    .clk(clk), .rst_n(rst_n), .strobe(ul_strobe), .addr(req_addr), .data(req_wdata),
    .open_o(wr_open), .err_o(unlock_err), .bad_o(ul_bad)
  );

  // status decision, in priority order per operation
  always_comb begin
    req_stat = ST_OK;
    if (!st_pass) req_stat = ST_NOTEST;
    else begin
      unique case (op)
        OP_READ: if (!in_map(addr32)) req_stat = ST_RANGE;
        OP_PROG: begin
          if (!in_map(addr32))                     req_stat = ST_RANGE;
          else if (!wr_open)                       req_stat = ST_LOCKED;
          else if (arr_rprog)                      req_stat = ST_ONCE;
          else if (is_life(addr32) && !ids_done)   req_stat = ST_ORDER;
          else if (!fmt_ok(addr32, req_wdata))     req_stat = ST_FORMAT;
        end
        OP_UNLK: if (ul_bad) req_stat = ST_BADKEY;
        default: req_stat = ST_OK;
      endcase
    end
  end

  assign arr_we = req_valid && op == OP_PROG && req_stat == ST_OK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      stat_q  <= ST_OK;
      rd_data <= '0;
    end else begin
      ack_q <= 1'b0;
      if (req_valid && op != OP_TEST) begin
        ack_q   <= 1'b1;
        stat_q  <= req_stat;
        rd_data <= (op == OP_READ && req_stat == ST_OK) ? arr_rdata : 32'h0;
      end
    end
  end

  assign ack          = ack_q || st_done;
  assign ack_status   = st_done ? (st_pass ? ST_OK : ST_NOTEST) : stat_q;
  assign test_ok      = st_pass;
  assign cfg_max_err  = feat_word[7:0];
  assign cfg_rekey_en = feat_word[15:8];
  assign cfg_test_off = tdis_word[2:0];

  // R2: nothing reaches the array before the self-test passes
  p_quiet_untested_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !test_ok |-> !arr_we);
  // R4: every array write happens with writes unlocked
  p_write_needs_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> wr_open);
  // R11: non-test requests are answered on the next cycle
  p_ack_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'd2) |=> ack);
endmodule

// File: tb/otp_guard_bench.sv
`timescale 1ns/1ps
module otp_guard_bench;
  localparam int DEPTH = 32;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic ack, test_ok, wr_open, unlock_err;
  logic [2:0] ack_status, cfg_test_off;
  logic [31:0] rd_data;
  logic [7:0] cfg_max_err, cfg_rekey_en;

  int total = 0;
  int bad = 0;
  logic got_prompt;
  logic [2:0] r_stat;
  logic [31:0] r_data;

  always #2.5 clk = ~clk;

  otp_guard #(.DEPTH(DEPTH)) u_otp_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .ack_status(ack_status),
    .rd_data(rd_data), .test_ok(test_ok), .wr_open(wr_open), .unlock_err(unlock_err),
    .cfg_max_err(cfg_max_err), .cfg_rekey_en(cfg_rekey_en), .cfg_test_off(cfg_test_off)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; returns status, data and whether ack came one cycle later
  task automatic issue(input logic [1:0] op, input int addr, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = AW'(addr); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    got_prompt = ack;
    for (int i = 0; i < 200 && !ack; i++) @(negedge clk);
    r_stat = ack_status;
    r_data = rd_data;
    @(negedge clk);
    chk("R11 ack pulse width", 32'(ack), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 ack", 32'(ack), 0);
    chk("R1 wr_open", 32'(wr_open), 0);
    chk("R1 test_ok", 32'(test_ok), 0);
    chk("R1 unlock_err", 32'(unlock_err), 0);
  endtask

  task automatic t_untested();
    issue(2'd0, 0, 0);           chk("R2 read before test", 32'(r_stat), 1);
    issue(2'd1, 5, 32'h1111);    chk("R2 program before test", 32'(r_stat), 1);
    issue(2'd3, 3, 32'h5555);    chk("R2 unlock before test", 32'(r_stat), 1);
    issue(2'd3, 4, 32'hAAAA);    chk("R2 unlock stays closed", 32'(wr_open), 0);
  endtask

  task automatic t_selftest();
    issue(2'd2, 0, 0);
    chk("R3 self-test status", 32'(r_stat), 0);
    chk("R3 test_ok", 32'(test_ok), 1);
    issue(2'd0, 5, 0);
    chk("R2 array untouched by early program", r_data, 0);
  endtask

  task automatic t_locked();
    issue(2'd1, 5, 32'h2222);
    chk("R4 program while locked", 32'(r_stat), 2);
    chk("R11 prompt ack", 32'(got_prompt), 1);
    issue(2'd0, 5, 0);
    chk("R4 locked write left no data", r_data, 0);
  endtask

  task automatic t_unlock();
    issue(2'd3, 4, 32'hAAAA);
    chk("R5 second step first", 32'(r_stat), 7);
    chk("R5 error raised", 32'(unlock_err), 1);
    issue(2'd3, 3, 32'h5555);    chk("R4 first step ok", 32'(r_stat), 0);
    issue(2'd3, 4, 32'h1234);    chk("R5 wrong data", 32'(r_stat), 7);
    chk("R5 still locked", 32'(wr_open), 0);
    issue(2'd3, 4, 32'hAAAA);    chk("R5 sequence restarted", 32'(r_stat), 7);
    issue(2'd3, 3, 32'h5555);
    issue(2'd3, 4, 32'hAAAA);
    chk("R4 opened", 32'(wr_open), 1);
    chk("R5 error cleared", 32'(unlock_err), 0);
  endtask

  task automatic t_prog_read();
    issue(2'd1, 5, 32'hDEAD_BEEF); chk("R6 program ok", 32'(r_stat), 0);
    issue(2'd0, 5, 0);             chk("R6 read back", r_data, 32'hDEAD_BEEF);
    issue(2'd0, 6, 0);             chk("R6 blank word", r_data, 0);
    issue(2'd0, 30, 0);            chk("R6 read out of map", 32'(r_stat), 5);
    issue(2'd1, 31, 32'h1);        chk("R6 program out of map", 32'(r_stat), 5);
  endtask

  task automatic t_once();
    issue(2'd1, 5, 32'h0BAD_0BAD); chk("R7 second program", 32'(r_stat), 3);
    issue(2'd0, 5, 0);             chk("R7 first value kept", r_data, 32'hDEAD_BEEF);
    issue(2'd1, 28, 32'hC0FF_EE01); chk("R7 chip id first", 32'(r_stat), 0);
    issue(2'd1, 28, 32'h1);        chk("R7 chip id locked", 32'(r_stat), 3);
  endtask

  task automatic t_order();
    issue(2'd1, 17, 32'h77);       chk("R8 lifecycle without scan id", 32'(r_stat), 4);
    issue(2'd0, 17, 0);            chk("R8 lifecycle untouched", r_data, 0);
    issue(2'd1, 29, 32'h1D1D_1D1D); chk("R8 scan id", 32'(r_stat), 0);
    issue(2'd1, 21, 32'h88);       chk("R8 lifecycle allowed", 32'(r_stat), 0);
    issue(2'd0, 21, 0);            chk("R8 lifecycle read", r_data, 32'h88);
  endtask

  task automatic t_format();
    issue(2'd1, 22, 32'h0001_0000); chk("R9 feature reserved", 32'(r_stat), 6);
    chk("R10 feature still blank", 32'(cfg_max_err), 0);
    issue(2'd1, 22, 32'h0000_A53C); chk("R9 feature ok", 32'(r_stat), 0);
    chk("R10 max err", 32'(cfg_max_err), 32'h3C);
    chk("R10 rekey enable", 32'(cfg_rekey_en), 32'hA5);
    issue(2'd1, 23, 32'h8);         chk("R9 test-disable reserved", 32'(r_stat), 6);
    chk("R10 test-off blank", 32'(cfg_test_off), 0);
    issue(2'd1, 23, 32'h5);         chk("R9 test-disable ok", 32'(r_stat), 0);
    chk("R10 test-off", 32'(cfg_test_off), 5);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog R11 actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_untested();
    t_selftest();
    t_locked();
    t_unlock();
    t_prog_read();
    t_once();
    t_order();
    t_format();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule